// File: doc/BRIEF.md
# Twisted-Ring Slot Divider

This block divides its clock by a fixed even number N using a twisted-ring shift chain of STAGES flops (N = 2*STAGES). The default of five stages gives ten count slots; four stages give eight. Each count slot has its own output line, high for exactly one clock period while the chain sits in that slot. A square-wave carry output completes one full period every N clocks, so it can clock a following divider.

The chain shifts the inverted last stage into the first stage on each enabled rising edge. A legal chain state changes in one bit per step. Each slot line is a two-input AND of stage bits, so a slot line only moves when one of its own two stage bits moves, and the lines do not glitch between counts. An active-low enable input (named `inhibit`, high means hold) gates counting. A synchronous active-high reset returns the chain to the zero count. A chain pattern outside the legal sequence, for example a power-up value, is cleared to the zero count on the next rising edge.

Top module: `twist_ring_divider`

## Requirements
- R1: With `rst` high at a rising edge, the next state is the zero count (all stages clear): `slot_o` equals 1 (bit 0 set) and `carry_o` is 1, whatever `inhibit` is.
- R2: With `rst` low and `inhibit` low, each rising edge moves the count from slot k to slot k+1, so `slot_o` bit k+1 is the only line set.
- R3: With `rst` low and `inhibit` high, a rising edge leaves `slot_o` and `carry_o` unchanged.
- R4: At every legal count exactly one bit of `slot_o` is 1.
- R5: `carry_o` is 1 while the count is in slots 0 to N/2-1 and 0 in slots N/2 to N-1, which gives a period of N enabled clocks and a 50% duty cycle.
- R6: STAGES=5 gives N=10 slot lines and STAGES=4 gives N=8. From slot N-1 the next enabled edge returns to slot 0.
- R7: A stage pattern with more than one transition between adjacent stages is illegal. On the next rising edge, whether `inhibit` is high or low, the chain loads the zero count, and counting then continues normally.
- R8: Between consecutive legal counts the stage chain changes in at most one bit. When the count advances, exactly two `slot_o` lines change: one falls and one rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the zero count |
| inhibit | input | 1 | High holds the count; low lets it advance |
| slot_o | output | 2*STAGES | One-hot slot lines, bit k set in count k |
| carry_o | output | 1 | Square wave with a period of 2*STAGES counts |

## Verification
The bench builds two instances on a shared clock. The first uses five stages and a legal power-up value. Its reset, hold and advance sequences cover wraparound, mid-count reset, and reset while `inhibit` is high. The second uses four stages with an illegal power-up pattern and never sees reset. This makes recovery through the correction path reachable, and it checks the divide-by-eight slot order and carry timing as the instance runs freely.

// File: rtl/jring_pkg.sv
package jring_pkg;

  localparam int unsigned MAX_STAGES = 16;

  // A twisted-ring state is legal when at most one adjacent pair of stages differs.
  function automatic logic ring_legal(input logic [MAX_STAGES-1:0] v, input int unsigned n);
    int unsigned edges;
    edges = 0;
    for (int unsigned i = 0; i + 1 < MAX_STAGES; i++) begin
      if (i + 1 < n && v[i] != v[i+1]) edges++;
    end
    return (edges <= 1);
  endfunction

endpackage

// File: rtl/jring_stages.sv
module jring_stages #(
  parameter int unsigned STAGES  = 5,
  parameter logic [STAGES-1:0] POWERUP = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inhibit,
  output logic [STAGES-1:0] state_o,
  output logic              legal_o
);
  import jring_pkg::*;

  logic [STAGES-1:0]     ring_q = POWERUP;
  logic [MAX_STAGES-1:0] ring_wide;
  logic                  legal;

  always_comb begin
    ring_wide = '0;
    ring_wide[STAGES-1:0] = ring_q;
  end

  assign legal = ring_legal(ring_wide, STAGES);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= '0;
    end else if (!legal) begin
      ring_q <= '0;
    end else if (!inhibit) begin
      ring_q <= {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
    end
  end

  assign state_o = ring_q;
  assign legal_o = legal;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (ring_q == '0));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (inhibit && legal) |=> $stable(ring_q));

  // R7
  illegal_recover_chk: assert property (@(posedge clk) disable iff (rst)
    !legal |=> (ring_q == '0));

  // R8
  single_bit_step_chk: assert property (@(posedge clk) disable iff (rst)
    legal |=> ($countones(ring_q ^ $past(ring_q)) <= 1));

endmodule

// File: rtl/jring_decode.sv
module jring_decode #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned SLOTS = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legal,
  input  logic [STAGES-1:0] state,
  output logic [SLOTS-1:0]  slot_o,
  output logic              carry_o
);

  // Each slot is one two-input gate on adjacent (or first/last) stages.
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k == 0) begin : g_zero
      assign slot_o[k] = ~state[0] & ~state[STAGES-1];
    end else if (k < STAGES) begin : g_fill
      assign slot_o[k] = state[k-1] & ~state[k];
    end else if (k == STAGES) begin : g_full
      assign slot_o[k] = state[0] & state[STAGES-1];
    end else begin : g_drain
      assign slot_o[k] = ~state[k-STAGES-1] & state[k-STAGES];
    end
  end

  assign carry_o = ~state[STAGES-1];

  // R4
  slot_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    legal |-> ($countones(slot_o) == 1));

endmodule

// File: rtl/twist_ring_divider.sv
module twist_ring_divider #(
  parameter int unsigned STAGES = 5,
  parameter logic [STAGES-1:0] POWERUP = '0,
  localparam int unsigned SLOTS = 2 * STAGES,
  localparam int unsigned HALF  = STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inhibit,
  output logic [SLOTS-1:0] slot_o,
  output logic             carry_o
);

  logic [STAGES-1:0] stage_w;
  logic              legal_w;

  jring_stages #(.STAGES(STAGES), .POWERUP(POWERUP)) u_stages (
    .clk     (clk),
    .rst     (rst),
    .inhibit (inhibit),
    .state_o (stage_w),
    .legal_o (legal_w)
  );

  jring_decode #(.STAGES(STAGES)) u_decode (
    .clk     (clk),
    .rst     (rst),
    .legal   (legal_w),
    .state   (stage_w),
    .slot_o  (slot_o),
    .carry_o (carry_o)
  );

  // R5
  carry_half_chk: assert property (@(posedge clk) disable iff (rst)
    legal_w |-> (carry_o == (|slot_o[HALF-1:0])));

  // R2
  advance_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (legal_w && !inhibit && !slot_o[SLOTS-1]) |=> (slot_o == ($past(slot_o) << 1)));

  // R6
  wrap_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (legal_w && !inhibit && slot_o[SLOTS-1]) |=> slot_o[0]);

endmodule

// File: tb/twist_ring_divider_bench.sv
`timescale 1ns/1ps
module twist_ring_divider_bench;
  localparam int ST  = 5;
  localparam int N   = 2 * ST;
  localparam int ST8 = 4;
  localparam int N8  = 2 * ST8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inhibit = 1'b1;
  logic [N-1:0]  slot;
  logic          carry;
  logic [N8-1:0] slot8;
  logic          carry8;

  twist_ring_divider #(.STAGES(ST)) u_twist_ring_divider (
    .clk(clk), .rst(rst), .inhibit(inhibit), .slot_o(slot), .carry_o(carry)
  );

  twist_ring_divider #(.STAGES(ST8), .POWERUP(4'b0100)) u_twist_ring_divider_b8 (
    .clk(clk), .rst(1'b0), .inhibit(1'b0), .slot_o(slot8), .carry_o(carry8)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [N-1:0] slots;
    logic         carry;
    string        req;
  } item_t;

  item_t        sb_q[$];
  item_t        cur;
  logic [N-1:0] prev_slots;
  bit           have_prev = 0;
  int compared   = 0;
  int mismatched = 0;
  int model      = 0;
  int e8         = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic r, input logic inh, input string req);
    item_t it;
    @(negedge clk);
    rst = r;
    inhibit = inh;
    @(posedge clk);
    #1;
    if (r) model = 0;
    else if (!inh) model = (model + 1) % N;
    it.slots = {{(N-1){1'b0}}, 1'b1} << model;
    it.carry = (model < N / 2);
    it.req   = req;
    sb_q.push_back(it);
  endtask

  // Monitor: pop expected items and compare away from the clock edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      check(cur.req, 32'(slot), 32'(cur.slots));
      check("R5", 32'(carry), 32'(cur.carry));
      check("R4", 32'($countones(slot)), 32'd1);
      if (have_prev && !rst) begin
        compared++;
        if ($countones(slot ^ prev_slots) != 0 && $countones(slot ^ prev_slots) != 2) begin
          mismatched++;
          $display("FAIL R8 actual=%0d changed lines expected=0 or 2", $countones(slot ^ prev_slots));
        end
      end
      prev_slots = slot;
      have_prev  = 1;
    end
  end

  // Divide-by-eight instance: starts illegal, free runs with no reset.
  always @(posedge clk) e8 <= e8 + 1;

  always @(negedge clk) begin
    if (e8 >= 1 && e8 <= 40) begin
      if (e8 == 1) check("R7", 32'(slot8), 32'd1);
      else         check("R6", 32'(slot8), 32'(1 << ((e8 - 1) % N8)));
      check("R5", 32'(carry8), 32'(((e8 - 1) % N8) < N8 / 2));
    end
  end

  initial begin
    drive(1'b1, 1'b1, "R1");
    drive(1'b1, 1'b0, "R1");
    for (int i = 0; i < 23; i++) drive(1'b0, 1'b0, (i >= 9) ? "R6" : "R2");
    for (int i = 0; i < 10; i++) drive(1'b0, i[0], "R3");
    for (int i = 0; i < 4; i++)  drive(1'b0, 1'b1, "R3");
    drive(1'b1, 1'b1, "R1");
    for (int i = 0; i < 12; i++) drive(1'b0, 1'b0, "R5");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule